// File: doc/BRIEF.md
# Sector Buffer Word Transfer Engine

This block takes decoded sector data from a byte-addressed buffer and hands it to a consumer one 16-bit word at a time. Each word is made from two neighbouring buffer bytes with the lower-addressed byte in the upper half. A register file loads a start address and a remaining byte count, then fires a start strobe. From then on the engine either serves host-polled word reads or runs DMA service slots into a word-addressed destination memory. A 3-bit destination selector picks which of these is allowed.

A polled read gives one word and moves the address and count on by two bytes. A DMA slot moves a full chunk of words, or a shorter final chunk once little data is left. The slot issues one destination write per cycle and holds while the destination is not ready. When the data runs out the engine ends the transfer in a single step. In that step it updates the host-side and interface-side status flags, and it may raise an interrupt request if the interrupt gates allow it.

Top module: `secbuf_xfer`

## Requirements
- R1: After reset the engine is idle. xferActive=0, hostEnd=0, dataReady=0, ifIdle=1, ifDteN=1, irq=0, countOut=0, bufAddr=0 and destValid=0.
- R2: In the idle state, ldAddr loads bufAddr and ldCount loads countOut. These loads take priority over the other requests in that cycle. A start strobe with no load sets xferActive=1 and dataReady=1, and clears hostEnd and ifIdle.
- R3: An accepted polled read happens when rdReq is high, the transfer is active, and destSel is 3 with rdIsSub=1 or destSel is 2 with rdIsSub=0. In the next cycle it gives rdValid=1 and rdData={buf[a],buf[a+1]}, where a is the old bufAddr. bufAddr then rises by 2 and countOut falls by 2.
- R4: A polled read made while the transfer is inactive, or with the wrong selector for the reader, gives rdValid=1 with rdData=0. bufAddr and countOut stay unchanged.
- R5: An accepted polled read with countOut ≤ 2 forces countOut to 0 and ends the transfer.
- R6: A DMA slot starts when slotReq is high, the transfer is active, and destSel is 5 or 7. With countOut > 2·SLOT_WORDS (512) it moves SLOT_WORDS words, countOut drops by 2·SLOT_WORDS, and the transfer stays active. Otherwise it moves (countOut+1)/2 words, ends the transfer, and sets countOut to 0.
- R7: The first destination byte address of a slot is dmaAddr<<3 when destSel=5, and dmaAddr[14:0]<<3 when destSel=7. Each accepted write (destValid and destReady) adds 2 to the address. destData packs bytes the same way as R3. While destReady is low, destAddr and bufAddr hold.
- R8: The buffer address is 16 bits wide and wraps from 0xFFFF to 0x0000. A byte pair may straddle the wrap.
- R9: Ending a transfer sets xferActive=0, hostEnd=1, dataReady=0 and ifIdle=1.
- R10: If dteIntEn is high when a transfer ends, ifDteN goes to 0. If irqMask5 is also high, irq pulses high for exactly one cycle. dteAck sets ifDteN back to 1.
- R11: slotReq has no effect while the transfer is inactive or while destSel is not 5 or 7. No write is issued, and countOut and bufAddr stay unchanged.
- R12: A slot started with countOut=0 issues no write, and ends the transfer on the cycle after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldAddr | input | 1 | Load buffer address strobe |
| ldAddrVal | input | 16 | Buffer start address |
| ldCount | input | 1 | Load byte count strobe |
| ldCountVal | input | 16 | Byte count value |
| start | input | 1 | Transfer start strobe |
| destSel | input | 3 | Destination select: 2 main read, 3 sub read, 5 program memory, 7 word memory |
| rdReq | input | 1 | Polled word read request |
| rdIsSub | input | 1 | Reader is the sub side |
| rdData | output | 16 | Polled read result |
| rdValid | output | 1 | rdData valid, one cycle after rdReq |
| bufAddr | output | 16 | Current buffer byte address |
| bufHi | input | 8 | Buffer byte at bufAddr |
| bufLo | input | 8 | Buffer byte at bufAddr+1 |
| slotReq | input | 1 | DMA service slot request |
| dmaAddr | input | 16 | DMA destination base register |
| destValid | output | 1 | Destination write valid |
| destReady | input | 1 | Destination accepts write |
| destAddr | output | 20 | Destination byte address |
| destData | output | 16 | Destination write word |
| dteIntEn | input | 1 | Transfer-end interrupt enable |
| irqMask5 | input | 1 | Level-5 interrupt mask |
| dteAck | input | 1 | Acknowledge transfer-end flag |
| xferActive | output | 1 | Transfer in progress |
| hostEnd | output | 1 | Host status: transfer ended |
| dataReady | output | 1 | Host status: data ready |
| ifIdle | output | 1 | Interface status: no transfer in progress |
| ifDteN | output | 1 | Interface status: transfer-end flag, active low |
| irq | output | 1 | Level-5 interrupt request pulse |
| countOut | output | 16 | Remaining byte count |

## Verification
The assertions assume three things about the inputs. First, destSel does not change while a DMA slot is running. Second, no load or start strobe arrives during a slot. Third, bufHi and bufLo always show the bytes at bufAddr and bufAddr+1, so a stalled write sees unchanged data. The stimulus meets these by setting the selector and loading registers only while the engine is idle, and by waiting for each slot's expected writes to drain before moving on. The stimulus models the buffer as a pure function of the byte address, so the packed words follow from the address alone.

// File: rtl/secbuf_pkg.sv
package secbuf_pkg;
  // Destination select codes
  localparam logic [2:0] SEL_MAIN = 3'd2;
  localparam logic [2:0] SEL_SUB  = 3'd3;
  localparam logic [2:0] SEL_PRG  = 3'd5;
  localparam logic [2:0] SEL_WORD = 3'd7;

  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic startXfer;
    logic pollStep;
    logic pollReject;
    logic slotLoad;
    logic beat;
    logic slotDone;
    logic terminate;
  } xfer_strobe_t;
endpackage

// File: rtl/secbuf_ctrl.sv
module secbuf_ctrl
  import secbuf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ldAddr,
  input  logic         ldCount,
  input  logic         start,
  input  logic         rdReq,
  input  logic         rdIsSub,
  input  logic [2:0]   destSel,
  input  logic         slotReq,
  input  logic         destReady,
  input  logic         active,
  input  logic         countLe2,
  input  logic         slotEmpty,
  input  logic         slotLastWord,
  input  logic         lastSlot,
  output xfer_strobe_t strb,
  output logic         inBurst
);
  typedef enum logic {S_IDLE, S_BURST} state_t;
  state_t state, stateNext;

  logic selOk;
  logic dmaSel;
  assign selOk  = (rdIsSub && destSel == SEL_SUB) || (!rdIsSub && destSel == SEL_MAIN);
  assign dmaSel = (destSel == SEL_PRG) || (destSel == SEL_WORD);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (ldAddr || ldCount) begin
          strb.loadAddr  = ldAddr;
          strb.loadCount = ldCount;
        end else if (start) begin
          strb.startXfer = 1'b1;
        end else if (rdReq) begin
          if (active && selOk) begin
            strb.pollStep  = 1'b1;
            strb.terminate = countLe2;
          end else begin
            strb.pollReject = 1'b1;
          end
        end else if (slotReq && active && dmaSel) begin
          strb.slotLoad = 1'b1;
          stateNext     = S_BURST;
        end
      end
      S_BURST: begin
        strb.pollReject = rdReq;
        if (slotEmpty) begin
          strb.slotDone  = 1'b1;
          strb.terminate = lastSlot;
          stateNext      = S_IDLE;
        end else if (destReady) begin
          strb.beat = 1'b1;
          if (slotLastWord) begin
            strb.slotDone  = 1'b1;
            strb.terminate = lastSlot;
            stateNext      = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign inBurst = (state == S_BURST);
endmodule

// File: rtl/secbuf_dp.sv
module secbuf_dp
  import secbuf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int SLOT_WORDS = 256,
  localparam int WCW       = $clog2(SLOT_WORDS + 1),
  localparam int DEST_W    = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_strobe_t      strb,
  input  logic [ADDR_W-1:0] ldAddrVal,
  input  logic [CNT_W-1:0]  ldCountVal,
  input  logic [2:0]        destSel,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [7:0]        bufHi,
  input  logic [7:0]        bufLo,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [CNT_W-1:0]  countOut,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic [DEST_W-1:0] destAddr,
  output logic              countLe2,
  output logic              slotEmpty,
  output logic              slotLastWord,
  output logic              lastSlot
);
  localparam int SLOT_BYTES = 2 * SLOT_WORDS;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  countQ;
  logic [15:0]       rdDataQ;
  logic              rdValidQ;
  logic [WCW-1:0]    remWords;
  logic [WCW-1:0]    slotWords;
  logic              lastSlotQ;
  logic [DEST_W-1:0] destAddrQ;

  // Slot sizing from the remaining count
  logic [CNT_W:0]    countP1;
  logic              smallCnt;
  logic [WCW-1:0]    sizeWords;
  logic [CNT_W-1:0]  slotBytes;
  assign countP1   = {1'b0, countQ} + (CNT_W+1)'(1);
  assign smallCnt  = ({1'b0, countQ} <= (CNT_W+1)'(SLOT_BYTES));
  assign sizeWords = smallCnt ? WCW'(countP1 >> 1) : WCW'(SLOT_WORDS);
  assign slotBytes = CNT_W'({slotWords, 1'b0});

  // Destination base: word memory drops the top address bit
  logic [ADDR_W-1:0] baseSrc;
  logic [DEST_W-1:0] destBase;
  always_comb begin
    baseSrc = dmaAddr;
    if (destSel == SEL_WORD) baseSrc[ADDR_W-1] = 1'b0;
    destBase = DEST_W'({baseSrc, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      countQ    <= '0;
      rdDataQ   <= '0;
      rdValidQ  <= 1'b0;
      remWords  <= '0;
      slotWords <= '0;
      lastSlotQ <= 1'b0;
      destAddrQ <= '0;
    end else begin
      rdValidQ <= strb.pollStep | strb.pollReject;
      if (strb.pollStep)        rdDataQ <= {bufHi, bufLo};
      else if (strb.pollReject) rdDataQ <= '0;

      if (strb.loadAddr)                  addrQ <= ldAddrVal;
      else if (strb.pollStep || strb.beat) addrQ <= addrQ + ADDR_W'(2);

      if (strb.loadCount) begin
        countQ <= ldCountVal;
      end else if (strb.pollStep) begin
        countQ <= strb.terminate ? '0 : countQ - CNT_W'(2);
      end else if (strb.slotDone) begin
        countQ <= lastSlotQ ? '0 : countQ - slotBytes;
      end

      if (strb.slotLoad) begin
        remWords  <= sizeWords;
        slotWords <= sizeWords;
        lastSlotQ <= smallCnt;
        destAddrQ <= destBase;
      end else if (strb.beat) begin
        remWords  <= remWords - WCW'(1);
        destAddrQ <= destAddrQ + DEST_W'(2);
      end
    end
  end

  assign bufAddr      = addrQ;
  assign countOut     = countQ;
  assign rdData       = rdDataQ;
  assign rdValid      = rdValidQ;
  assign destAddr     = destAddrQ;
  assign countLe2     = (countQ <= CNT_W'(2));
  assign slotEmpty    = (remWords == '0);
  assign slotLastWord = (remWords == WCW'(1));
  assign lastSlot     = lastSlotQ;
endmodule

// File: rtl/secbuf_status.sv
module secbuf_status
  import secbuf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  xfer_strobe_t strb,
  input  logic         dteIntEn,
  input  logic         irqMask5,
  input  logic         dteAck,
  output logic         active,
  output logic         hostEnd,
  output logic         dataReady,
  output logic         ifIdle,
  output logic         ifDteN,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      hostEnd   <= 1'b0;
      dataReady <= 1'b0;
      ifIdle    <= 1'b1;
      ifDteN    <= 1'b1;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strb.startXfer) begin
        active    <= 1'b1;
        hostEnd   <= 1'b0;
        dataReady <= 1'b1;
        ifIdle    <= 1'b0;
      end else if (strb.terminate) begin
        active    <= 1'b0;
        hostEnd   <= 1'b1;
        dataReady <= 1'b0;
        ifIdle    <= 1'b1;
      end
      if (strb.terminate && dteIntEn) begin
        ifDteN <= 1'b0;
        irq    <= irqMask5;
      end else if (dteAck) begin
        ifDteN <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/secbuf_xfer.sv
module secbuf_xfer
  import secbuf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int SLOT_WORDS = 256,
  localparam int DEST_W    = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldAddr,
  input  logic [ADDR_W-1:0] ldAddrVal,
  input  logic              ldCount,
  input  logic [CNT_W-1:0]  ldCountVal,
  input  logic              start,
  input  logic [2:0]        destSel,
  input  logic              rdReq,
  input  logic              rdIsSub,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufHi,
  input  logic [7:0]        bufLo,
  input  logic              slotReq,
  input  logic [ADDR_W-1:0] dmaAddr,
  output logic              destValid,
  input  logic              destReady,
  output logic [DEST_W-1:0] destAddr,
  output logic [15:0]       destData,
  input  logic              dteIntEn,
  input  logic              irqMask5,
  input  logic              dteAck,
  output logic              xferActive,
  output logic              hostEnd,
  output logic              dataReady,
  output logic              ifIdle,
  output logic              ifDteN,
  output logic              irq,
  output logic [CNT_W-1:0]  countOut
);
  xfer_strobe_t strb;
  logic inBurst, countLe2, slotEmpty, slotLastWord, lastSlot;

  secbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ldAddr(ldAddr), .ldCount(ldCount), .start(start),
    .rdReq(rdReq), .rdIsSub(rdIsSub), .destSel(destSel), .slotReq(slotReq),
    .destReady(destReady), .active(xferActive), .countLe2(countLe2),
    .slotEmpty(slotEmpty), .slotLastWord(slotLastWord), .lastSlot(lastSlot),
    .strb(strb), .inBurst(inBurst)
  );

  secbuf_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOT_WORDS(SLOT_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldAddrVal(ldAddrVal),
    .ldCountVal(ldCountVal), .destSel(destSel), .dmaAddr(dmaAddr),
    .bufHi(bufHi), .bufLo(bufLo), .bufAddr(bufAddr), .countOut(countOut),
    .rdData(rdData), .rdValid(rdValid), .destAddr(destAddr),
    .countLe2(countLe2), .slotEmpty(slotEmpty), .slotLastWord(slotLastWord),
    .lastSlot(lastSlot)
  );

  secbuf_status u_status (
    .clk(clk), .rstN(rstN), .strb(strb), .dteIntEn(dteIntEn),
    .irqMask5(irqMask5), .dteAck(dteAck), .active(xferActive),
    .hostEnd(hostEnd), .dataReady(dataReady), .ifIdle(ifIdle),
    .ifDteN(ifDteN), .irq(irq)
  );

  assign destValid = inBurst && !slotEmpty;
  assign destData  = {bufHi, bufLo};
endmodule

// File: rtl/secbuf_xfer_chk.sv
module secbuf_xfer_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEST_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              ldAddr,
  input logic              ldCount,
  input logic              start,
  input logic [2:0]        destSel,
  input logic              rdReq,
  input logic              rdIsSub,
  input logic [15:0]       rdData,
  input logic              rdValid,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              destValid,
  input logic              destReady,
  input logic [DEST_W-1:0] destAddr,
  input logic              xferActive,
  input logic              hostEnd,
  input logic              ifIdle,
  input logic              ifDteN,
  input logic              irq,
  input logic [CNT_W-1:0]  countOut
);
  logic selMatch, plainRead;
  assign selMatch  = (rdIsSub && destSel == 3'd3) || (!rdIsSub && destSel == 3'd2);
  assign plainRead = rdReq && !ldAddr && !ldCount && !start && !destValid;

  // R10: interrupt request lasts one cycle
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R10: interrupt only alongside an ended transfer with the flag low
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (hostEnd && !xferActive && !ifDteN));

  // R9: end status and active are exclusive
  p_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostEnd |-> !xferActive) and (xferActive |-> !ifIdle));

  // R7: stalled write holds its address and buffer position
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (destValid && !destReady) |=> (destValid && $stable(destAddr) && $stable(bufAddr)));

  // R7: consecutive writes step by two bytes
  p_dest_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (destValid && destReady) |=> (!destValid || destAddr == DEST_W'($past(destAddr) + DEST_W'(2))));

  // R4: rejected read returns zero and leaves state alone
  p_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (plainRead && !(xferActive && selMatch)) |=>
      (rdValid && rdData == 16'h0 && $stable(bufAddr) && $stable(countOut)));

  // R3: accepted read advances the address
  p_poll_r3: assert property (@(posedge clk) disable iff (!rstN)
    (plainRead && xferActive && selMatch) |=>
      (rdValid && bufAddr == ADDR_W'($past(bufAddr) + ADDR_W'(2))));

  // R5: final polled read clears the count and ends the transfer
  p_poll_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (plainRead && xferActive && selMatch && countOut <= CNT_W'(2)) |=>
      (countOut == '0 && !xferActive));
endmodule

bind secbuf_xfer secbuf_xfer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rstN(rstN), .ldAddr(ldAddr), .ldCount(ldCount), .start(start),
  .destSel(destSel), .rdReq(rdReq), .rdIsSub(rdIsSub), .rdData(rdData),
  .rdValid(rdValid), .bufAddr(bufAddr), .destValid(destValid),
  .destReady(destReady), .destAddr(destAddr), .xferActive(xferActive),
  .hostEnd(hostEnd), .ifIdle(ifIdle), .ifDteN(ifDteN), .irq(irq),
  .countOut(countOut)
);

// File: tb/sim_secbuf_xfer.sv
`timescale 1ns/1ps
module sim_secbuf_xfer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldAddr = 0, ldCount = 0, start = 0, rdReq = 0, rdIsSub = 0, slotReq = 0;
  logic [15:0] ldAddrVal = '0, ldCountVal = '0, dmaAddr = '0;
  logic [2:0]  destSel = '0;
  logic destReady = 0, dteIntEn = 0, irqMask5 = 0, dteAck = 0;
  logic [15:0] rdData, bufAddr, countOut, destData;
  logic rdValid, destValid, xferActive, hostEnd, dataReady, ifIdle, ifDteN, irq;
  logic [19:0] destAddr;
  logic [7:0]  bufHi, bufLo;

  int checks = 0, failures = 0, irqSeen = 0;
  bit done = 0;
  logic [15:0] rdQ[$];
  logic [35:0] destQ[$];
  logic [15:0] mAddr, mCnt;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] bufByte(input logic [15:0] a);
    return 8'((a * 16'd37) >> 3) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bufHi = bufByte(bufAddr);
  assign bufLo = bufByte(bufAddr + 16'd1);

  secbuf_xfer u0 (
    .clk(clk), .rstN(rstN), .ldAddr(ldAddr), .ldAddrVal(ldAddrVal),
    .ldCount(ldCount), .ldCountVal(ldCountVal), .start(start),
    .destSel(destSel), .rdReq(rdReq), .rdIsSub(rdIsSub), .rdData(rdData),
    .rdValid(rdValid), .bufAddr(bufAddr), .bufHi(bufHi), .bufLo(bufLo),
    .slotReq(slotReq), .dmaAddr(dmaAddr), .destValid(destValid),
    .destReady(destReady), .destAddr(destAddr), .destData(destData),
    .dteIntEn(dteIntEn), .irqMask5(irqMask5), .dteAck(dteAck),
    .xferActive(xferActive), .hostEnd(hostEnd), .dataReady(dataReady),
    .ifIdle(ifIdle), .ifDteN(ifDteN), .irq(irq), .countOut(countOut)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] packWord(input logic [15:0] a);
    return {bufByte(a), bufByte(a + 16'd1)};
  endfunction

  // Backpressure pattern on the destination
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      destReady = (cyc % 4 != 2) && (cyc % 7 != 5);
      cyc++;
    end
  end

  // Monitor: pop and compare as results appear
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN) begin
        if (irq) irqSeen++;
        if (rdValid) begin
          if (rdQ.size() == 0) chk("R3 unexpected read result", 36'(rdData), 36'h0);
          else chk("R3/R4 polled word", 36'(rdData), 36'(rdQ.pop_front()));
        end
        if (destValid && destReady) begin
          if (destQ.size() == 0) chk("R11 unexpected write", {destAddr, destData}, 36'h0);
          else chk("R7 destination write", {destAddr, destData}, destQ.pop_front());
        end
      end
    end
  end

  task automatic look();
    #2;
  endtask

  task automatic loadGo(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk); ldAddr = 1; ldCount = 1; ldAddrVal = a; ldCountVal = c;
    @(negedge clk); ldAddr = 0; ldCount = 0; start = 1;
    @(negedge clk); start = 0;
    mAddr = a; mCnt = c;
  endtask

  task automatic pollRead(input bit sub, input bit ok);
    @(negedge clk); rdReq = 1; rdIsSub = sub;
    if (ok) begin
      rdQ.push_back(packWord(mAddr));
      mAddr = mAddr + 16'd2;
      mCnt = (mCnt <= 16'd2) ? 16'd0 : mCnt - 16'd2;
    end else begin
      rdQ.push_back(16'h0);
    end
    @(negedge clk); rdReq = 0;
  endtask

  task automatic ackDte();
    @(negedge clk); dteAck = 1;
    @(negedge clk); dteAck = 0;
  endtask

  task automatic runSlot(input bit accepted);
    int words;
    logic [19:0] base;
    if (accepted) begin
      words = (mCnt <= 16'd512) ? (int'(mCnt) + 1) / 2 : 256;
      base = (destSel == 3'd7) ? 20'({1'b0, dmaAddr[14:0]} << 3) : 20'({dmaAddr} << 3);
      for (int i = 0; i < words; i++) begin
        destQ.push_back({base + 20'(2 * i), packWord(mAddr)});
        mAddr = mAddr + 16'd2;
      end
      mCnt = (mCnt <= 16'd512) ? 16'd0 : mCnt - 16'd512;
    end
    @(negedge clk); slotReq = 1;
    @(negedge clk); slotReq = 0;
    begin
      int g = 0;
      while (destQ.size() > 0 && g < 5000) begin @(posedge clk); g++; end
    end
    @(negedge clk);
    look();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); look();
    // R1 reset state
    chk("R1 active", 36'(xferActive), 36'h0);
    chk("R1 flags hostEnd,dataReady,ifIdle,ifDteN,irq",
        36'({hostEnd, dataReady, ifIdle, ifDteN, irq}), 36'b00110);
    chk("R1 count,addr", 36'({countOut, bufAddr}), 36'h0);
    chk("R1 destValid", 36'(destValid), 36'h0);

    // R2 load and start, main-side polled reader
    dteIntEn = 1; irqMask5 = 1; destSel = 3'd2;
    loadGo(16'h0100, 16'd6); look();
    chk("R2 start flags active,hostEnd,dataReady,ifIdle",
        36'({xferActive, hostEnd, dataReady, ifIdle}), 36'b1010);
    chk("R2 loaded addr,count", 36'({bufAddr, countOut}), 36'({16'h0100, 16'd6}));

    // R4 wrong reader for selector 2
    pollRead(1, 0); look();
    chk("R4 mismatch keeps addr,count", 36'({bufAddr, countOut}), 36'({16'h0100, 16'd6}));

    // R3 accepted reads
    pollRead(0, 1); look();
    chk("R3 addr,count after read", 36'({bufAddr, countOut}), 36'({16'h0102, 16'd4}));
    pollRead(0, 1);
    pollRead(0, 1); look();
    // R5 / R9 / R10 termination
    chk("R5 count zero, inactive", 36'({countOut, xferActive}), 36'({16'd0, 1'b0}));
    chk("R9 end flags hostEnd,dataReady,ifIdle", 36'({hostEnd, dataReady, ifIdle}), 36'b101);
    chk("R10 ifDteN low", 36'(ifDteN), 36'h0);
    @(negedge clk); look();
    chk("R10 one irq pulse", 36'(irqSeen), 36'd1);

    // R4 read while inactive
    pollRead(0, 0); look();
    chk("R4 inactive keeps addr", 36'(bufAddr), 36'h0106);
    ackDte(); look();
    chk("R10 dteAck restores flag", 36'(ifDteN), 36'h1);

    // R8 wrap with the sub-side reader, irq masked
    irqMask5 = 0; destSel = 3'd3;
    loadGo(16'hFFFC, 16'd5);
    pollRead(1, 1); pollRead(1, 1); pollRead(1, 1); look();
    chk("R8 address wrapped", 36'(bufAddr), 36'h0002);
    chk("R5 odd count ends", 36'({countOut, xferActive}), 36'h0);
    @(negedge clk); look();
    chk("R10 masked irq stays quiet", 36'({irqSeen, ifDteN}), 36'({32'd1, 1'b0}));
    ackDte();

    // R6 multi-slot DMA to program memory
    irqMask5 = 1; destSel = 3'd5; dmaAddr = 16'h0012;
    loadGo(16'h0200, 16'd1030);
    runSlot(1);
    chk("R6 full slot count,active", 36'({countOut, xferActive}), 36'({16'd518, 1'b1}));
    runSlot(1);
    chk("R6 second slot count,active", 36'({countOut, xferActive}), 36'({16'd6, 1'b1}));
    runSlot(1);
    chk("R6 short slot ends", 36'({countOut, xferActive, hostEnd}), 36'({16'd0, 2'b01}));
    chk("R6 buffer addr after slots", 36'(bufAddr), 36'h0606);
    @(negedge clk); look();
    chk("R10 irq after DMA end", 36'(irqSeen), 36'd2);
    ackDte();

    // R7 word memory target drops top address bit, R8 wrap mid-pair
    destSel = 3'd7; dmaAddr = 16'h8003;
    loadGo(16'hFFFE, 16'd3);
    runSlot(1);
    chk("R7 word target done", 36'({bufAddr, destValid, xferActive}), 36'({16'h0002, 2'b00}));

    // R11 slot with a polled selector is ignored
    destSel = 3'd2;
    loadGo(16'h0300, 16'd100);
    runSlot(0);
    repeat (3) @(negedge clk);
    look();
    chk("R11 bad selector ignored", 36'({countOut, bufAddr, xferActive}),
        36'({16'd100, 16'h0300, 1'b1}));
    destSel = 3'd5; dmaAddr = 16'h0040;
    runSlot(1);
    chk("R6 50-word slot ends", 36'({countOut, xferActive}), 36'h0);
    runSlot(0);
    repeat (3) @(negedge clk);
    look();
    chk("R11 inactive slot ignored", 36'({countOut, bufAddr}), 36'({16'd0, 16'h0364}));

    // R12 zero-count slot
    destSel = 3'd7;
    loadGo(16'h0400, 16'd0); look();
    chk("R12 active before slot", 36'(xferActive), 36'h1);
    runSlot(1);
    chk("R12 zero slot ends without writes",
        36'({countOut, bufAddr, xferActive, hostEnd}), 36'({16'd0, 16'h0400, 2'b01}));

    repeat (4) @(negedge clk);
    chk("R3 read queue drained", 36'(rdQ.size()), 36'h0);
    chk("R7 write queue drained", 36'(destQ.size()), 36'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule